// File: doc/BRIEF.md
# Two-Wire Bus Master with Internal-Address Phase

This block is a register-mapped master for a two-wire serial bus in the I2C style. Software selects a 7-bit target address, a direction and an optional 0 to 3 byte internal address. It then launches a transaction by writing the transmit holding register (for writes), a start command (for reads) or a quick command. The block produces START, the address byte, the internal-address bytes, the data bytes and STOP on its own. A read that carries an internal address switches direction through a repeated START.

Bit timing comes from a single-cycle `tick` input that marks each half period of SCL. Both lines are open-drain: an output of 1 releases the line. Progress and errors show up as status flags. An enable/disable pair of write-only registers builds an interrupt mask, and `irq` combines the flags with that mask.

Register offsets on `addr` are: 0 control, 1 mode, 2 internal address, 3 status, 4 interrupt enable, 5 interrupt disable, 6 mask readback, 7 receive holding, 8 transmit holding.

Top module: `twi_master`

## Requirements
- R1: After reset, status reads 0x005 (bit0 complete and bit2 transmit ready set, every other flag clear), the mask reads 0, `irq` is 0 and both `scl_o` and `sda_o` are 1.
- R2: With control bit2 (master enable) set and mode bit12 clear, a write to the transmit holding register sends START, the address byte {addr[6:0],0}, each byte written and STOP. Status bit0 drops as soon as the holding register is written.
- R3: Mode bits 9:8 give the internal-address byte count (0 to 3). Those bytes are taken from the internal-address register and sent right after the address byte, most significant first.
- R4: A read (mode bit12 set) with a non-zero internal-address count sends {addr,0}, the internal-address bytes, a repeated START and then {addr,1} before receiving data.
- R5: Writing control bit0 (START) and bit1 (STOP) together in read mode receives exactly one byte, answers it with NACK and sends STOP.
- R6: During a read, a pending STOP request makes the master NACK the byte being received and then send STOP. Every earlier byte is acknowledged.
- R7: Control bit6 (quick command) sends only START, the address byte with the mode direction, and STOP.
- R8: A NACK on the address or on a written byte sets status bit8, drops any pending transmit byte and sends STOP. Reading status clears bit8.
- R9: A byte that completes while status bit1 (receive ready) is still set sets status bit6 (overrun), and the receive register then holds the newer byte. Reading status clears bit6.
- R10: When a written byte has been acknowledged, no further byte is waiting and no STOP has been requested, status bit7 (underrun) is set and STOP is sent. Reading status clears bit7.
- R11: A write at offset 4 sets mask bits, a write at offset 5 clears them, offset 6 reads the mask back, and `irq` is high exactly when some status bit and its mask bit are both set.
- R12: Writing control bit7 returns every register to its reset value, including the master enable. With the master enable clear, no command starts bus activity.
- R13: Status bit0 is a live level: it stays set across repeated status reads while idle and returns high only after STOP has been sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Half-period pulse for SCL timing |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects) |
| addr | input | 4 | Register offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |
| scl_o | output | 1 | Clock line, 0 pulls low |
| sda_o | output | 1 | Data line, 0 pulls low |
| sda_i | input | 1 | Sensed data line level |

## Verification
The bench runs a behavioural bus target that logs every START, STOP, byte and acknowledge. It goes after the read endings: a design that decides the last byte at the wrong time returns one byte too many, or NACKs a byte too early, in R5 and R6. It also checks that a NACKed address drops the pending byte; a design that keeps it would restart the bus by itself. Overrun and underrun are provoked on purpose, and a design that kept these flags sticky across a status read, or that let completion clear on read, shows a wrong second status value.

// File: rtl/twi_master.sv
module twi_master #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          irq,
  output logic          scl_o,
  output logic          sda_o,
  input  logic          sda_i
);
  localparam logic [AW-1:0] A_CTRL = 0, A_MODE = 1, A_IADR = 2, A_STAT = 3,
                            A_IEN = 4, A_IDIS = 5, A_IMSK = 6, A_RHR = 7, A_THR = 8;
  localparam logic [8:0] FLAGS = 9'h1C7;

  typedef enum logic [2:0] {IDLE, STA, BITS, STO, RSTA} st_t;
  typedef enum logic [2:0] {B_ADDR, B_IADR, B_RADDR, B_TXD, B_RXD} step_t;

  st_t         state;
  step_t       step;
  logic [1:0]  ph;
  logic [3:0]  bitn;
  logic [7:0]  sh, thr, rhr;
  logic [6:0]  dev;
  logic        mread;
  logic [1:0]  iadr_n, iadr_left;
  logic [23:0] iadr_r;
  logic [8:0]  mask;
  logic        msen, stop_req, quick, rx_last;
  logic        thr_full, rxrdy, ovre, unre, nack;

  wire ctl_wr   = wr_en && addr == A_CTRL;
  wire swrst    = ctl_wr && wdata[7];
  wire stop_now = stop_req || (ctl_wr && wdata[1]);
  wire thr_wr   = wr_en && addr == A_THR;
  wire stat_rd  = rd_en && addr == A_STAT;
  wire rhr_rd   = rd_en && addr == A_RHR;
  wire txcomp   = state == IDLE && !thr_full;
  wire [8:0] status = {nack, unre, ovre, 3'b000, !thr_full, rxrdy, txcomp};
  wire go = state == IDLE && msen &&
            ((ctl_wr && (wdata[0] || wdata[6])) || (thr_full && !mread));
  wire quick_now = ctl_wr && wdata[6];
  wire [7:0] iadr_byte = iadr_r[{iadr_left - 2'd1, 3'b000} +: 8];
  wire nxt_tx = step == B_TXD ||
                (step == B_ADDR && !quick && iadr_left == 0 && !mread) ||
                (step == B_IADR && iadr_left == 0 && !mread);
  wire unused_hi = ^wdata[31:24];

  assign irq = |(status & mask);

  always_comb begin
    rdata = '0;
    case (addr)
      A_MODE:  rdata = {9'b0, dev, 3'b0, mread, 2'b0, iadr_n, 8'b0};
      A_IADR:  rdata = {8'b0, iadr_r};
      A_STAT:  rdata = {23'b0, status};
      A_IMSK:  rdata = {23'b0, mask};
      A_RHR:   rdata = {24'b0, rhr};
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || swrst) begin
      state <= IDLE; step <= B_ADDR; ph <= '0; bitn <= '0;
      sh <= '0; thr <= '0; rhr <= '0; dev <= '0; mread <= 1'b0;
      iadr_n <= '0; iadr_left <= '0; iadr_r <= '0; mask <= '0;
      msen <= 1'b0; stop_req <= 1'b0; quick <= 1'b0; rx_last <= 1'b0;
      thr_full <= 1'b0; rxrdy <= 1'b0; ovre <= 1'b0; unre <= 1'b0; nack <= 1'b0;
      scl_o <= 1'b1; sda_o <= 1'b1;
    end else begin
      if (ctl_wr && wdata[2]) msen <= 1'b1;
      if (ctl_wr && wdata[1]) stop_req <= 1'b1;
      if (wr_en && addr == A_MODE) begin
        dev <= wdata[22:16]; mread <= wdata[12]; iadr_n <= wdata[9:8];
      end
      if (wr_en && addr == A_IADR) iadr_r <= wdata[23:0];
      if (wr_en && addr == A_IEN)  mask <= mask | (wdata[8:0] & FLAGS);
      if (wr_en && addr == A_IDIS) mask <= mask & ~wdata[8:0];
      if (thr_wr) begin thr <= wdata[7:0]; thr_full <= 1'b1; end
      if (stat_rd) begin ovre <= 1'b0; unre <= 1'b0; nack <= 1'b0; end
      if (rhr_rd) rxrdy <= 1'b0;

      if (go) begin
        state <= STA; ph <= '0; step <= B_ADDR;
        quick <= quick_now;
        stop_req <= ctl_wr && wdata[1];
        iadr_left <= iadr_n;
        sh <= {dev, mread && (iadr_n == 0 || quick_now)};
      end else if (tick) begin
        case (state)
          STA: if (ph == 0) begin sda_o <= 1'b0; ph <= 2'd1; end
               else begin scl_o <= 1'b0; state <= BITS; ph <= '0; bitn <= '0; end
          BITS: if (ph == 0) begin
            scl_o <= 1'b0; ph <= 2'd1;
            if (bitn == 4'd8) begin
              if (step == B_RXD) begin sda_o <= stop_now; rx_last <= stop_now; end
              else sda_o <= 1'b1;
            end else sda_o <= (step == B_RXD) ? 1'b1 : sh[7];
          end else begin
            scl_o <= 1'b1; ph <= '0;
            if (bitn != 4'd8) begin
              sh <= {sh[6:0], sda_i}; bitn <= bitn + 4'd1;
            end else begin
              bitn <= '0;
              if (step == B_RXD) begin
                rhr <= sh;
                if (rxrdy && !rhr_rd) ovre <= 1'b1;
                rxrdy <= 1'b1;
                if (rx_last) state <= STO;
              end else if (sda_i) begin
                nack <= 1'b1; thr_full <= 1'b0; state <= STO;
              end else if (nxt_tx) begin
                if (thr_full) begin sh <= thr; thr_full <= 1'b0; step <= B_TXD; end
                else begin
                  if (!stop_now) unre <= 1'b1;
                  state <= STO;
                end
              end else begin
                case (step)
                  B_ADDR, B_IADR:
                    if (step == B_ADDR && quick) state <= STO;
                    else if (iadr_left != 0) begin
                      step <= B_IADR; sh <= iadr_byte; iadr_left <= iadr_left - 2'd1;
                    end else if (step == B_ADDR) step <= B_RXD;
                    else begin state <= RSTA; step <= B_RADDR; sh <= {dev, 1'b1}; end
                  default: step <= B_RXD;
                endcase
              end
            end
          end
          STO: case (ph)
            2'd0: begin scl_o <= 1'b0; sda_o <= 1'b0; ph <= 2'd1; end
            2'd1: begin scl_o <= 1'b1; ph <= 2'd2; end
            default: begin sda_o <= 1'b1; state <= IDLE; stop_req <= 1'b0; ph <= '0; end
          endcase
          RSTA: case (ph)
            2'd0: begin scl_o <= 1'b0; sda_o <= 1'b1; ph <= 2'd1; end
            2'd1: begin scl_o <= 1'b1; ph <= 2'd2; end
            2'd2: begin sda_o <= 1'b0; ph <= 2'd3; end
            default: begin scl_o <= 1'b0; state <= BITS; ph <= '0; bitn <= '0; end
          endcase
          default: ;
        endcase
      end
    end
  end

  p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
    state == IDLE |-> scl_o && sda_o);
  p_sda_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == BITS && $past(state) == BITS && scl_o && $past(scl_o)) |-> $stable(sda_o));
  p_nack_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nack) |-> state == STO);
  p_ovre_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovre) |-> rxrdy);
  p_unre_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unre) |-> state == STO && !thr_full);
  p_mask_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_IEN) |=> ((mask & $past(wdata[8:0] & FLAGS)) == $past(wdata[8:0] & FLAGS)));
  p_comp_high_r13: assert property (@(posedge clk) disable iff (!rst_n)
    txcomp |-> scl_o && sda_o);
endmodule

// File: tb/sim_twi_master.sv
module sim_twi_master;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic irq, scl_o, sda_o;
  logic s_sda = 1;
  wire sda_bus = sda_o & s_sda;

  twi_master u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
                 .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq),
                 .scl_o(scl_o), .sda_o(sda_o), .sda_i(sda_bus));

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, tcnt = 0;
  int log_q[$], exp_q[$], rdq[$];
  int nack_idx = -1;
  logic [31:0] st_acc;

  always @(negedge clk) begin
    tcnt = (tcnt + 1) % 4;
    tick = (tcnt == 0);
  end

  // bus target model
  logic scl_p = 1, sda_p = 1, cur_rx = 1, dir_tx = 0;
  int bitc = 0, rxcnt = 0;
  logic [7:0] sbyte = 0, rdbyte = 8'hFF;
  always @(negedge clk) begin
    if (scl_o && scl_p && sda_p && !sda_bus) begin
      log_q.push_back(1000); bitc = 0; rxcnt = 0; dir_tx = 0; s_sda = 1;
    end else if (scl_o && scl_p && !sda_p && sda_bus) begin
      log_q.push_back(1001); bitc = 0; dir_tx = 0; s_sda = 1;
    end else if (scl_o && !scl_p) begin
      if (bitc < 8) begin
        if (cur_rx) sbyte = {sbyte[6:0], sda_bus};
        bitc++;
        if (bitc == 8 && cur_rx) begin
          log_q.push_back(int'(sbyte));
          if (rxcnt == 0) dir_tx = sbyte[0] && (nack_idx != 0);
        end
      end else begin
        if (!cur_rx) begin
          log_q.push_back(sda_bus ? 1003 : 1002);
          if (sda_bus) dir_tx = 0;
        end else rxcnt++;
        bitc = 0;
      end
    end else if (!scl_o && scl_p) begin
      if (bitc == 8) s_sda = cur_rx ? (rxcnt == nack_idx) : 1'b1;
      else if (bitc == 0) begin
        cur_rx = !dir_tx;
        if (!cur_rx) begin
          rdbyte = (rdq.size() > 0) ? 8'(rdq.pop_front()) : 8'hFF;
          s_sda = rdbyte[7];
        end else s_sda = 1;
      end else s_sda = cur_rx ? 1'b1 : rdbyte[7-bitc];
    end
    scl_p = scl_o; sda_p = sda_bus;
  end

  task automatic summary();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog R2 actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_log(input string tag);
    int bad = -1;
    checks++;
    foreach (exp_q[i]) if (bad < 0 && (i >= log_q.size() || log_q[i] != exp_q[i])) bad = i;
    if (bad < 0 && log_q.size() != exp_q.size()) bad = exp_q.size();
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s bus log at %0d actual=%p expected=%p", tag, bad, log_q, exp_q);
    end
    log_q.delete();
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = 4'(a); wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = 4'(a); #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3, s); st_acc |= s;
      if (s[0]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_bit(input int b);
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(3, s); st_acc |= s;
      if (s[b]) break;
    end
  endtask

  function automatic logic [31:0] mode(input int dv, input int r, input int n);
    return (32'(dv) << 16) | (32'(r) << 12) | (32'(n) << 8);
  endfunction

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    rd(3, v); chk("R1 status", v, 32'h005);
    rd(6, v); chk("R1 mask", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 lines", {scl_o, sda_o}, 2'b11);

    wr(0, 32'h24);
    // R2 write
    wr(1, mode(7'h50, 0, 0));
    wr(8, 32'hA5);
    rd(3, v); chk("R2 completion low after holding write", v[0], 0);
    wait_bit(2);
    wr(8, 32'h3C); wr(0, 32'h02);
    st_acc = 0; wait_done();
    exp_q = '{1000, 'hA0, 'hA5, 'h3C, 1001}; check_log("R2 write sequence");
    chk("R10 no underrun on normal write", st_acc[7], 0);

    // R3 internal address, two bytes
    wr(1, mode(7'h50, 0, 2)); wr(2, 32'hABCD12);
    wr(8, 32'h77); wr(0, 32'h02);
    wait_done();
    exp_q = '{1000, 'hA0, 'hCD, 'h12, 'h77, 1001}; check_log("R3 internal address order");

    // R4 / R6 read with internal address, three bytes
    rdq = '{'h11, 'h22, 'h33};
    wr(1, mode(7'h50, 1, 1)); wr(2, 32'h5A);
    wr(0, 32'h01);
    for (int k = 0; k < 3; k++) begin
      wait_bit(1);
      rd(7, v); chk("R4 read data", v, 'h11 * (k + 1));
      if (k == 1) wr(0, 32'h02);
    end
    wait_done();
    exp_q = '{1000, 'hA0, 'h5A, 1000, 'hA1, 1002, 1002, 1003, 1001};
    check_log("R4 R6 repeated start and final NACK");

    // R5 single byte read
    rdq = '{'h9E};
    wr(1, mode(7'h50, 1, 0)); wr(0, 32'h03);
    wait_done();
    exp_q = '{1000, 'hA1, 1003, 1001}; check_log("R5 one byte read");
    rd(7, v); chk("R5 byte", v, 'h9E);

    // R7 quick
    wr(1, mode(7'h50, 0, 0)); wr(0, 32'h40);
    wait_done();
    exp_q = '{1000, 'hA0, 1001}; check_log("R7 quick command");

    // R8 NACK on address
    nack_idx = 0;
    wr(8, 32'h55); wr(0, 32'h02);
    st_acc = 0; wait_done();
    exp_q = '{1000, 'hA0, 1001}; check_log("R8 address NACK");
    chk("R8 flag seen", st_acc[8], 1);
    rd(3, v); chk("R8 flag cleared by read", v[8], 0);
    chk("R8 holding dropped", v[2], 1);
    // NACK on data byte
    nack_idx = 1;
    wr(8, 32'h66); wait_bit(2); wr(8, 32'h67); wr(0, 32'h02);
    st_acc = 0; wait_done();
    exp_q = '{1000, 'hA0, 'h66, 1001}; check_log("R8 data NACK");
    chk("R8 data flag", st_acc[8], 1);
    nack_idx = -1;
    rd(3, v);

    // R10 underrun
    wr(8, 32'h42);
    st_acc = 0; wait_done();
    exp_q = '{1000, 'hA0, 'h42, 1001}; check_log("R10 underrun stop");
    chk("R10 underrun flag", st_acc[7], 1);
    rd(3, v); chk("R10 cleared by read", v[7], 0);

    // R9 overrun
    rdq = '{'hC1, 'hC2};
    wr(1, mode(7'h50, 1, 0)); wr(0, 32'h01);
    wait_bit(1); wr(0, 32'h02);
    st_acc = 0; wait_done();
    exp_q = '{1000, 'hA1, 1002, 1003, 1001}; check_log("R9 overrun sequence");
    chk("R9 overrun flag", st_acc[6], 1);
    rd(7, v); chk("R9 newer byte kept", v, 'hC2);
    rd(3, v); chk("R9 cleared", v[6], 0);

    // R11 interrupts
    wr(4, 32'h001); #1 chk("R11 irq on complete", irq, 1);
    rd(6, v); chk("R11 mask readback", v, 32'h001);
    wr(5, 32'h001); #1 chk("R11 irq off", irq, 0);
    wr(4, 32'h100); #1 chk("R11 nack masked idle", irq, 0);
    wr(4, 32'h004); #1 chk("R11 irq on transmit ready", irq, 1);
    wr(5, 32'h1FF); rd(6, v); chk("R11 mask cleared", v, 0);

    // R13 live completion
    rd(3, v); chk("R13 first read", v[0], 1);
    rd(3, v); chk("R13 second read", v[0], 1);

    // R12 software reset
    wr(1, mode(7'h50, 1, 1)); wr(4, 32'h007);
    wr(0, 32'h80);
    rd(1, v); chk("R12 mode reset", v, 0);
    rd(6, v); chk("R12 mask reset", v, 0);
    rd(3, v); chk("R12 status reset", v, 32'h005);
    wr(0, 32'h40);
    repeat (200) @(negedge clk);
    exp_q = {}; check_log("R12 no activity without enable");

    summary();
    $finish;
  end
endmodule